// File: doc/BRIEF.md
# SCL Stuck-Line Timeout Detector

This block watches the clock line of a two-wire serial bus and reports a hang: a period in which SCL holds one level for longer than a set number of reference ticks. The raw SCL level is resynchronized into the local clock domain. A tick counter then runs while SCL stays at a watched level. Any change of the synchronized level restarts the count. When the counter runs past its top value, a sticky timeout flag is raised. Software clears the flag with a one-cycle clear pulse.

Counting is gated in two ways. First, a global enable and the bus role must allow it: the bus busy with this node as master, the bus busy with this node as an addressed slave, or the bus free with a start waiting. Second, the current SCL level must be one of the watched levels. The counter advances only on cycles where the prescaler tick input is high. A mode input picks between a long and a short overflow point.

Top module: `scl_tmo_det`

## Requirements
- R1: After reset, `tmo_flag_o` is 0 and `tmo_count_o` is 0.
- R2: `scl_i` passes through a two-stage synchronizer. A change of the synchronized level clears the count on the next clock edge. A change of `scl_i` therefore shows as a count of zero three clock edges after it is sampled.
- R3: While counting is allowed and the level is steady, the count grows by one on each clock edge where `tick_i` is 1. It holds its value when `tick_i` is 0.
- R4: With `short_mode_i` = 0, the count runs through 0 .. 2^LW-1. The tick that finds it at 2^LW-1 is an overflow. On that edge the count returns to 0 and `tmo_flag_o` becomes 1. The flag rises only on an overflow.
- R5: With `short_mode_i` = 1, the top value is 2^SW-1. A count at or above that value overflows on the next tick, including a count reached earlier in long mode.
- R6: While `tmo_en_i` is 0, the count stays at zero and no overflow occurs.
- R7: Counting is allowed only in three cases: `bus_busy_i`=1 and `master_i`=1; `bus_busy_i`=1, `master_i`=0 and `addr_match_i`=1; `bus_busy_i`=0 and `start_req_i`=1. In every other case the count is held at zero.
- R8: `cnt_low_en_i` allows counting while synchronized SCL is 0, and `cnt_high_en_i` allows it while SCL is 1. At a level whose enable is 0 the count is held at zero. With both enables at 0 the counter stays idle.
- R9: `tmo_flag_o` stays at 1 until a cycle with `flag_clr_i` = 1. The flag then reads 0 after that clock edge.
- R10: If `flag_clr_i` is 1 in the same cycle as an overflow, `tmo_flag_o` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw SCL line level |
| tick_i | input | 1 | Prescaled reference tick, one clock wide |
| tmo_en_i | input | 1 | Timeout detection enable |
| bus_busy_i | input | 1 | Bus busy status |
| master_i | input | 1 | 1 = this node is master, 0 = slave |
| addr_match_i | input | 1 | Own slave address has matched |
| start_req_i | input | 1 | Start condition requested |
| short_mode_i | input | 1 | 0 = long (LW-bit) span, 1 = short (SW-bit) span |
| cnt_low_en_i | input | 1 | Count while SCL is low |
| cnt_high_en_i | input | 1 | Count while SCL is high |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the flag |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| tmo_count_o | output | LW | Live tick count |

## Verification
Results are due at these clock edges:
- A step of `tick_i`, the enable, the role inputs, the level enables or the clear pulse changes the count or the flag on the first clock edge that samples it.
- A change of `scl_i` reaches the count only on the third edge, because it passes two synchronizer stages and the edge compare first.
- An overflow updates the wrapped count and the set flag on the same edge.

The bench drives inputs on falling clock edges. A behavioural model steps on each rising edge: it keeps the synchronizer history in a queue and the count in an integer. Both outputs are compared with the model at the next falling edge, so every compare lands after the edge on which the result is due. Directed checks at chosen points confirm the overflow, clear and idle cases against values worked out by hand.

// File: rtl/scl_tmo_pkg.sv
package scl_tmo_pkg;

  // Bus role inputs that decide whether the watchdog may run.
  typedef struct packed {
    logic busy;
    logic master;
    logic addr_match;
    logic start_req;
  } bus_role_t;

  // True when the bus role allows hang monitoring.
  function automatic logic role_qualifies(bus_role_t r);
    logic as_master;
    logic as_slave;
    logic pre_start;
    as_master = r.busy & r.master;
    as_slave  = r.busy & ~r.master & r.addr_match;
    pre_start = ~r.busy & r.start_req;
    return as_master | as_slave | pre_start;
  endfunction

  // Select the per-level enable matching the present SCL level.
  function automatic logic level_watched(logic lvl, logic lo_en, logic hi_en);
    return lvl ? hi_en : lo_en;
  endfunction

  // Largest value an n-bit counter holds.
  function automatic int unsigned top_count(int unsigned w);
    if (w >= 32) return 32'hFFFF_FFFF;
    return (32'd1 << w) - 32'd1;
  endfunction

endpackage

// File: rtl/scl_tmo_sync.sv
module scl_tmo_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic lvl_o,
  output logic chg_o
);
  // Stages 0..STAGES-1 synchronize; the last stage keeps the prior level.
  localparam int unsigned TAPS = STAGES + 1;

  logic [TAPS-1:0] shreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg <= '1;  // idle bus sits high
    end else begin
      shreg <= {shreg[TAPS-2:0], scl_i};
    end
  end

  assign lvl_o = shreg[STAGES-1];
  assign chg_o = shreg[STAGES-1] ^ shreg[STAGES];

endmodule

// File: rtl/scl_tmo_qual.sv
module scl_tmo_qual
  import scl_tmo_pkg::*;
(
  input  logic      en_i,
  input  bus_role_t role_i,
  input  logic      lvl_i,
  input  logic      lo_en_i,
  input  logic      hi_en_i,
  output logic      monitor_o,
  output logic      active_o
);
  assign monitor_o = en_i & role_qualifies(role_i);
  assign active_o  = monitor_o & level_watched(lvl_i, lo_en_i, hi_en_i);
endmodule

// File: rtl/scl_tmo_ctr.sv
module scl_tmo_ctr
  import scl_tmo_pkg::*;
#(
  parameter int unsigned LW = 16,
  parameter int unsigned SW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          scl_chg_i,
  input  logic          tick_i,
  input  logic          short_i,
  output logic [LW-1:0] count_o,
  output logic          ovf_o
);
  localparam logic [LW-1:0] TOP_LONG  = LW'(top_count(LW));
  localparam logic [LW-1:0] TOP_SHORT = LW'(top_count(SW));

  logic [LW-1:0] cnt_q;
  logic [LW-1:0] top_sel;
  logic          at_top;
  logic          restart;

  assign top_sel = short_i ? TOP_SHORT : TOP_LONG;
  // ">=" so a count left above the short top by a mode switch still trips.
  assign at_top  = (cnt_q >= top_sel);
  assign restart = ~active_i | scl_chg_i;
  assign ovf_o   = ~restart & tick_i & at_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= at_top ? '0 : cnt_q + LW'(1);
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/scl_tmo_flag.sv
module scl_tmo_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;  // a new overflow beats a clear
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/scl_tmo_det.sv
module scl_tmo_det
  import scl_tmo_pkg::*;
#(
  parameter int unsigned LW = 16,
  parameter int unsigned SW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          tick_i,
  input  logic          tmo_en_i,
  input  logic          bus_busy_i,
  input  logic          master_i,
  input  logic          addr_match_i,
  input  logic          start_req_i,
  input  logic          short_mode_i,
  input  logic          cnt_low_en_i,
  input  logic          cnt_high_en_i,
  input  logic          flag_clr_i,
  output logic          tmo_flag_o,
  output logic [LW-1:0] tmo_count_o
);
  // Named internal events, visible to the bound checker.
  logic      scl_lvl;
  logic      scl_edge;
  logic      mon_ok;
  logic      cnt_active;
  logic      ovf_pulse;
  bus_role_t role;

  assign role = '{busy: bus_busy_i, master: master_i,
                  addr_match: addr_match_i, start_req: start_req_i};

  scl_tmo_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .lvl_o  (scl_lvl),
    .chg_o  (scl_edge)
  );

  scl_tmo_qual u_qual (
    .en_i      (tmo_en_i),
    .role_i    (role),
    .lvl_i     (scl_lvl),
    .lo_en_i   (cnt_low_en_i),
    .hi_en_i   (cnt_high_en_i),
    .monitor_o (mon_ok),
    .active_o  (cnt_active)
  );

  scl_tmo_ctr #(.LW(LW), .SW(SW)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (cnt_active),
    .scl_chg_i (scl_edge),
    .tick_i    (tick_i),
    .short_i   (short_mode_i),
    .count_o   (tmo_count_o),
    .ovf_o     (ovf_pulse)
  );

  scl_tmo_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf_pulse),
    .clr_i  (flag_clr_i),
    .flag_o (tmo_flag_o)
  );

endmodule

// File: rtl/scl_tmo_chk.sv
module scl_tmo_chk #(
  parameter int unsigned LW = 16,
  parameter int unsigned SW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          tmo_en_i,
  input logic          flag_clr_i,
  input logic          tmo_flag_o,
  input logic [LW-1:0] tmo_count_o,
  input logic          scl_edge,
  input logic          mon_ok,
  input logic          cnt_active,
  input logic          ovf_pulse
);
  p_edge_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_edge |=> tmo_count_o == '0);

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_active && !scl_edge && tick_i && !ovf_pulse)
      |=> tmo_count_o == LW'($past(tmo_count_o) + LW'(1)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_active && !scl_edge && !tick_i) |=> $stable(tmo_count_o));

  p_ovf_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_pulse |=> (tmo_flag_o && tmo_count_o == '0));

  p_rise_on_ovf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmo_flag_o && !ovf_pulse) |=> !tmo_flag_o);

  p_disabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmo_en_i |=> tmo_count_o == '0);

  p_unqualified_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_ok |-> !ovf_pulse);

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_flag_o && !flag_clr_i) |=> tmo_flag_o);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !ovf_pulse) |=> !tmo_flag_o);

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && ovf_pulse) |=> tmo_flag_o);

endmodule

bind scl_tmo_det scl_tmo_chk #(.LW(LW), .SW(SW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .tmo_en_i    (tmo_en_i),
  .flag_clr_i  (flag_clr_i),
  .tmo_flag_o  (tmo_flag_o),
  .tmo_count_o (tmo_count_o),
  .scl_edge    (scl_edge),
  .mon_ok      (mon_ok),
  .cnt_active  (cnt_active),
  .ovf_pulse   (ovf_pulse)
);

// File: tb/scl_tmo_det_tb_top.sv
module scl_tmo_det_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 6;
  localparam int SW = 4;
  localparam int LIM_LONG  = 1 << LW;
  localparam int LIM_SHORT = 1 << SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, tick = 1'b0, en = 1'b0, busy = 1'b0, mst = 1'b0;
  logic match = 1'b0, start = 1'b0, shrt = 1'b0, lo_en = 1'b0, hi_en = 1'b0, clr = 1'b0;
  logic          flag;
  logic [LW-1:0] count;

  int checks = 0;
  int fails  = 0;
  int tick_div = 1;
  int cyc = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_tmo_det #(.LW(LW), .SW(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .tick_i(tick),
    .tmo_en_i(en), .bus_busy_i(busy), .master_i(mst), .addr_match_i(match),
    .start_req_i(start), .short_mode_i(shrt), .cnt_low_en_i(lo_en),
    .cnt_high_en_i(hi_en), .flag_clr_i(clr),
    .tmo_flag_o(flag), .tmo_count_o(count)
  );

  // ---------------- behavioural reference ----------------
  int  hist[$] = '{1, 1, 1};  // [0] newest sample, [1] settled level, [2] previous level
  int  m_cnt  = 0;
  bit  m_flag = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{1, 1, 1};
      m_cnt = 0;
      m_flag = 0;
    end else begin
      bit allowed, watched, moved, over;
      int lim;
      allowed = en && ((busy && mst) || (busy && !mst && match) || (!busy && start));
      watched = (hist[1] == 1) ? hi_en : lo_en;
      moved   = (hist[1] != hist[2]);
      lim     = shrt ? LIM_SHORT : LIM_LONG;
      over    = 0;
      if (!(allowed && watched) || moved) m_cnt = 0;
      else if (tick) begin
        if (m_cnt >= lim - 1) begin m_cnt = 0; over = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (over) m_flag = 1;
      else if (clr) m_flag = 0;
      hist.push_front(int'(scl));
      void'(hist.pop_back());
    end
  end

  task automatic check(bit ok, string req, int act, int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp_v, $time);
    end
  endtask

  // Every-cycle comparison against the model, at the falling edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(int'(count) == m_cnt, {cur_req, " count"}, int'(count), m_cnt);
      check(flag == m_flag, {cur_req, " flag"}, int'(flag), int'(m_flag));
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      tick = (cyc % tick_div) == 0;
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic finish_up();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(flag == 1'b0 && count == '0, "R1 reset", int'(flag) + int'(count), 0);

    // R4: master, low level, long span
    cur_req = "R4";
    en = 1; busy = 1; mst = 1; lo_en = 1; scl = 0;
    run(3 + LIM_LONG + 2);
    check(flag == 1'b1, "R4 long overflow", int'(flag), 1);

    // R9: clear pulse
    cur_req = "R9";
    en = 0;
    pulse_clear();
    check(flag == 1'b0, "R9 cleared", int'(flag), 0);
    run(10);
    check(flag == 1'b0, "R9 stays clear", int'(flag), 0);
    en = 1;

    // R2: toggling SCL keeps the count short
    cur_req = "R2";
    hi_en = 1;
    for (int k = 0; k < 12; k++) begin
      scl = ~scl;
      run(20);
    end
    check(flag == 1'b0, "R2 no overflow with edges", int'(flag), 0);
    check(int'(count) < 25, "R2 count bounded", int'(count), 24);

    // R5: short span, high level only
    cur_req = "R5";
    lo_en = 0; scl = 1; shrt = 1;
    run(3 + LIM_SHORT + 2);
    check(flag == 1'b1, "R5 short overflow", int'(flag), 1);
    pulse_clear();
    // R5: switch from long to short above the short top
    shrt = 0; scl = 0; lo_en = 1; hi_en = 0;
    run(3 + 40);
    check(int'(count) > LIM_SHORT, "R5 long count above short top", int'(count), LIM_SHORT + 1);
    shrt = 1;
    run(2);
    check(flag == 1'b1 && count <= 1, "R5 overflow after switch", int'(flag), 1);
    shrt = 0;
    pulse_clear();

    // R6: disabled
    cur_req = "R6";
    en = 0;
    run(LIM_LONG + 10);
    check(count == '0 && flag == 1'b0, "R6 idle when disabled", int'(count) + int'(flag), 0);
    en = 1;

    // R7: role qualification
    cur_req = "R7";
    mst = 0; match = 0;
    run(20);
    check(count == '0, "R7 slave unaddressed", int'(count), 0);
    match = 1;
    run(20);
    check(int'(count) == 20, "R7 slave addressed", int'(count), 20);
    busy = 0; match = 0; start = 0;
    run(5);
    check(count == '0, "R7 free no start", int'(count), 0);
    start = 1;
    run(10);
    check(int'(count) == 10, "R7 free with start", int'(count), 10);

    // R8: level enables
    cur_req = "R8";
    lo_en = 0; hi_en = 0;
    run(10);
    check(count == '0, "R8 both off", int'(count), 0);
    hi_en = 1;
    run(10);
    check(count == '0, "R8 low level not watched", int'(count), 0);

    // R3: slower tick
    cur_req = "R3";
    hi_en = 0; lo_en = 1; tick_div = 3;
    run(31);
    check(int'(count) >= 9 && int'(count) <= 11, "R3 one step per tick", int'(count), 10);
    tick_div = 1;

    // R10: clear in the same cycle as an overflow
    cur_req = "R10";
    busy = 1; mst = 1; start = 0;
    run(3 + LIM_LONG + 2);
    check(flag == 1'b1, "R10 flag set first", int'(flag), 1);
    while (m_cnt != LIM_LONG - 1) run(1);
    clr = 1'b1;
    run(1);
    clr = 1'b0;
    check(flag == 1'b1 && count == '0, "R10 set beats clear", int'(flag), 1);

    run(5);
    finish_up();
  end
endmodule